// File: doc/BRIEF.md
# Transmit Stall Watchdog

This block watches a transmit path for a stall and escalates its recovery. A slow scheduler raises `tick` for one cycle at each check interval. On that cycle the block samples four free-running counts: transmitted frames, received pause frames, transmit start-of-packet events and an upstream drop count. It compares them with what it saved at the previous tick and reaches a verdict. The verdict is PROGRESS when frames or pauses moved. It is BUSY when nothing moved but start-of-packet events are pending. It is STALL when the drop count moved while start-of-packet activity stayed at zero on this tick and the one before. Otherwise it is QUIET.

A STALL normally produces a toggle action. The block drives `tx_en` low for a fixed window, then returns it to the configured value. Consecutive stalls are counted by an escalation counter. Once that count passes a limit, the next stall asks for a full MAC reset instead, and the count starts again. The reset sequence itself is carried out elsewhere. The action is reported as a 2-bit code with a one-cycle valid strobe.

The enable gate is a two-state machine. GATE_PASS passes `tx_en_cfg` to `tx_en`. A toggle action moves it from GATE_PASS to GATE_LOW. In GATE_LOW, `tx_en` is held low while the window counts down. When the window ends, the gate returns from GATE_LOW to GATE_PASS. If a further toggle arrives during GATE_LOW, the window restarts.

Top module: `txwd_top`

## Requirements
- R1: After reset, `act_valid` is 0, `act_code` is 0, `tx_en` equals `tx_en_cfg`, all saved samples are zero (the saved start-of-packet count counts as zero), and the escalation count is zero.
- R2: `act_valid` is high for exactly the one cycle after each `tick` cycle. `act_code` is 0 (none), 1 (toggle) or 2 (reset) while valid, and 0 whenever `act_valid` is low.
- R3: If the frame count or the pause count differs from its saved value, the action is none and the escalation count is cleared.
- R4: If frame and pause counts are unchanged and the start-of-packet count is nonzero, the action is none.
- R5: A stall is declared when frame and pause counts are unchanged, the start-of-packet count is zero, the drop count differs from its saved value, and the saved start-of-packet count is zero.
- R6: If frame and pause counts are unchanged and the start-of-packet count is zero but no stall is declared, the action is none and the escalation count is cleared.
- R7: On a stall with escalation count at most TOGGLE_LIMIT (default 4), the action is toggle and the count increments. On a stall with a count above TOGGLE_LIMIT, the action is reset and the count clears. With the defaults, six consecutive stalls give five toggles and then one reset.
- R8: Every tick stores all four current samples for the next comparison, whatever the verdict.
- R9: After a toggle action, `tx_en` is low for OFF_CYCLES cycles (default 4), starting the cycle after `act_valid`. It then follows `tx_en_cfg` again. A low `tx_en_cfg` always gives a low `tx_en`.
- R10: A reset or none action leaves `tx_en` equal to `tx_en_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle check strobe |
| frame_cnt | input | CNT_W | Transmitted frame count |
| pause_cnt | input | CNT_W | Received pause frame count |
| sop_cnt | input | CNT_W | Transmit start-of-packet count |
| drop_cnt | input | CNT_W | Upstream drop count |
| tx_en_cfg | input | 1 | Configured transmit enable |
| tx_en | output | 1 | Transmit enable after the recovery gate |
| act_valid | output | 1 | Action strobe, one cycle per tick |
| act_code | output | 2 | Action: 0 none, 1 toggle, 2 reset |

## Verification
A wrong saved sample has no effect at the time it is stored. It shows on the next tick, as a toggle where none was due, or a missing one: for example, a frame count that matches its stale copy, or a start-of-packet zero flag that was not stored. A wrong escalation count shows only at the end of a run of stalls, when the reset code appears one stall early or late. The tests therefore run full escalation sequences, both after a clear and after a reset. A gate fault shows on `tx_en` from one to OFF_CYCLES+1 cycles after the action strobe, so the window is checked cycle by cycle.

// File: rtl/txwd_pkg.sv
package txwd_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_RESET  = 2'd2
    } act_e;

    typedef enum logic [1:0] {
        V_PROGRESS = 2'd0,
        V_BUSY     = 2'd1,
        V_STALL    = 2'd2,
        V_QUIET    = 2'd3
    } verdict_e;

    typedef enum logic {
        GATE_PASS = 1'b0,
        GATE_LOW  = 1'b1
    } gate_e;

endpackage

// File: rtl/txwd_snap.sv
// Holds the samples taken at the previous tick and flags what has moved since.
module txwd_snap #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] frame_cnt,
    input  logic [CNT_W-1:0] pause_cnt,
    input  logic [CNT_W-1:0] sop_cnt,
    input  logic [CNT_W-1:0] drop_cnt,
    output logic             frame_moved,
    output logic             pause_moved,
    output logic             drop_moved,
    output logic             sop_zero,
    output logic             prev_sop_zero
);
    localparam int NUM_TRACK = 3;

    logic [NUM_TRACK-1:0][CNT_W-1:0] cur_vals;
    logic [NUM_TRACK-1:0]            moved;
    logic                            sop_zero_q;

    assign cur_vals[0] = frame_cnt;
    assign cur_vals[1] = pause_cnt;
    assign cur_vals[2] = drop_cnt;

    // One saved copy and one compare per tracked count.
    for (genvar g = 0; g < NUM_TRACK; g++) begin : g_track
        logic [CNT_W-1:0] saved_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                saved_q <= '0;
            else if (tick)
                saved_q <= cur_vals[g];
        end
        assign moved[g] = (saved_q != cur_vals[g]);
    end

    // Only the zero-ness of the start-of-packet count matters later on.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sop_zero_q <= 1'b1;
        else if (tick)
            sop_zero_q <= sop_zero;
    end

    assign sop_zero      = (sop_cnt == '0);
    assign prev_sop_zero = sop_zero_q;
    assign frame_moved   = moved[0];
    assign pause_moved   = moved[1];
    assign drop_moved    = moved[2];

endmodule

// File: rtl/txwd_judge.sv
// Turns the movement flags into a single verdict (combinational).
module txwd_judge
    import txwd_pkg::*;
(
    input  logic     frame_moved,
    input  logic     pause_moved,
    input  logic     drop_moved,
    input  logic     sop_zero,
    input  logic     prev_sop_zero,
    output verdict_e verdict
);
    always_comb begin
        if (frame_moved || pause_moved)
            verdict = V_PROGRESS;
        else if (!sop_zero)
            verdict = V_BUSY;
        else if (drop_moved && prev_sop_zero)
            verdict = V_STALL;
        else
            verdict = V_QUIET;
    end
endmodule

// File: rtl/txwd_escal.sv
// Counts consecutive stalls and registers the action for the tick.
module txwd_escal
    import txwd_pkg::*;
#(
    parameter int TOGGLE_LIMIT = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  verdict_e verdict,
    output logic     act_valid,
    output act_e     act_code,
    output logic [$clog2(TOGGLE_LIMIT+2)-1:0] esc_cnt
);
    localparam int ESC_W = $clog2(TOGGLE_LIMIT + 2);
    localparam logic [ESC_W-1:0] LIMIT = ESC_W'(TOGGLE_LIMIT);

    logic [ESC_W-1:0] cnt_q, cnt_d;
    act_e             act_d;

    always_comb begin
        cnt_d = cnt_q;
        act_d = ACT_NONE;
        unique case (verdict)
            V_PROGRESS: cnt_d = '0;
            V_BUSY:     cnt_d = cnt_q;
            V_QUIET:    cnt_d = '0;
            V_STALL: begin
                if (cnt_q > LIMIT) begin
                    act_d = ACT_RESET;
                    cnt_d = '0;
                end else begin
                    act_d = ACT_TOGGLE;
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            act_valid <= 1'b0;
            act_code  <= ACT_NONE;
        end else begin
            act_valid <= tick;
            act_code  <= tick ? act_d : ACT_NONE;
            if (tick)
                cnt_q <= cnt_d;
        end
    end

    assign esc_cnt = cnt_q;
endmodule

// File: rtl/txwd_gate.sv
// Holds transmit enable low for a fixed window after a toggle action.
module txwd_gate
    import txwd_pkg::*;
#(
    parameter int OFF_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic tx_en_cfg,
    output logic tx_en
);
    localparam int OFF_W = $clog2(OFF_CYCLES + 1);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_CYCLES - 1);

    gate_e            state_q;
    logic [OFF_W-1:0] left_q;

    // State register and window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_PASS;
            left_q  <= '0;
        end else begin
            unique case (state_q)
                GATE_PASS: begin
                    if (kick) begin
                        state_q <= GATE_LOW;
                        left_q  <= OFF_LAST;
                    end
                end
                GATE_LOW: begin
                    if (kick)
                        left_q <= OFF_LAST;
                    else if (left_q == '0)
                        state_q <= GATE_PASS;
                    else
                        left_q <= left_q - 1'b1;
                end
            endcase
        end
    end

    // Output process.
    always_comb begin
        unique case (state_q)
            GATE_PASS: tx_en = tx_en_cfg;
            GATE_LOW:  tx_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/txwd_top.sv
module txwd_top
    import txwd_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int TOGGLE_LIMIT = 4,
    parameter int OFF_CYCLES   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] frame_cnt,
    input  logic [CNT_W-1:0] pause_cnt,
    input  logic [CNT_W-1:0] sop_cnt,
    input  logic [CNT_W-1:0] drop_cnt,
    input  logic             tx_en_cfg,
    output logic             tx_en,
    output logic             act_valid,
    output logic [1:0]       act_code
);
    localparam int ESC_W = $clog2(TOGGLE_LIMIT + 2);

    logic             frame_moved, pause_moved, drop_moved;
    logic             sop_zero, prev_sop_zero;
    verdict_e         verdict;
    act_e             act_q;
    logic [ESC_W-1:0] esc_cnt;

    txwd_snap #(.CNT_W(CNT_W)) u_snap (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .frame_cnt     (frame_cnt),
        .pause_cnt     (pause_cnt),
        .sop_cnt       (sop_cnt),
        .drop_cnt      (drop_cnt),
        .frame_moved   (frame_moved),
        .pause_moved   (pause_moved),
        .drop_moved    (drop_moved),
        .sop_zero      (sop_zero),
        .prev_sop_zero (prev_sop_zero)
    );

    txwd_judge u_judge (
        .frame_moved   (frame_moved),
        .pause_moved   (pause_moved),
        .drop_moved    (drop_moved),
        .sop_zero      (sop_zero),
        .prev_sop_zero (prev_sop_zero),
        .verdict       (verdict)
    );

    txwd_escal #(.TOGGLE_LIMIT(TOGGLE_LIMIT)) u_escal (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .verdict   (verdict),
        .act_valid (act_valid),
        .act_code  (act_q),
        .esc_cnt   (esc_cnt)
    );

    txwd_gate #(.OFF_CYCLES(OFF_CYCLES)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick      (act_valid && (act_q == ACT_TOGGLE)),
        .tx_en_cfg (tx_en_cfg),
        .tx_en     (tx_en)
    );

    assign act_code = act_q;
endmodule

// File: rtl/txwd_chk.sv
module txwd_chk
    import txwd_pkg::*;
#(
    parameter int TOGGLE_LIMIT = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       tx_en_cfg,
    input logic       tx_en,
    input logic       act_valid,
    input logic [1:0] act_code,
    input verdict_e   verdict,
    input logic [$clog2(TOGGLE_LIMIT+2)-1:0] esc_cnt
);
    // R2
    valid_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> $past(tick));
    // R2
    code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_valid |-> act_code == 2'd0);
    // R2
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_code != 2'd3);
    // R3
    progress_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && verdict == V_PROGRESS) |=> act_code == 2'd0);
    // R7
    reset_after_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_code == 2'd2) |-> $past(esc_cnt) > ($clog2(TOGGLE_LIMIT+2))'(TOGGLE_LIMIT));
    // R9
    toggle_drops_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_code == 2'd1) |=> !tx_en);
    // R9
    cfg_low_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_cfg |-> !tx_en);
endmodule

bind txwd_top txwd_chk #(.TOGGLE_LIMIT(TOGGLE_LIMIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .tx_en_cfg (tx_en_cfg),
    .tx_en     (tx_en),
    .act_valid (act_valid),
    .act_code  (act_code),
    .verdict   (verdict),
    .esc_cnt   (esc_cnt)
);

// File: tb/test_txwd_top.sv
`timescale 1ns/1ps
module test_txwd_top;
    localparam int CNT_W = 16;
    localparam int OFF   = 4;
    localparam logic [1:0] C_NONE = 2'd0, C_TOG = 2'd1, C_RST = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [CNT_W-1:0] frame_cnt = '0, pause_cnt = '0, sop_cnt = '0, drop_cnt = '0;
    logic tx_en_cfg = 1'b1;
    logic tx_en, act_valid;
    logic [1:0] act_code;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    txwd_top #(.CNT_W(CNT_W), .TOGGLE_LIMIT(4), .OFF_CYCLES(OFF)) i_txwd_top (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .frame_cnt(frame_cnt), .pause_cnt(pause_cnt),
        .sop_cnt(sop_cnt), .drop_cnt(drop_cnt),
        .tx_en_cfg(tx_en_cfg), .tx_en(tx_en),
        .act_valid(act_valid), .act_code(act_code)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One tick with the given samples; checks the strobe, the code and the gate window.
    task automatic pulse(input int f, input int p, input int s, input int d,
                         input logic [1:0] exp, input string req);
        @(negedge clk);
        frame_cnt = CNT_W'(f); pause_cnt = CNT_W'(p);
        sop_cnt = CNT_W'(s); drop_cnt = CNT_W'(d);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check({req, " R2 valid"}, int'(act_valid), 1);
        check({req, " code"}, int'(act_code), int'(exp));
        for (int i = 0; i < OFF; i++) begin
            @(negedge clk);
            if (i == 0) begin
                check("R2 strobe width", int'(act_valid), 0);
                check("R2 idle code", int'(act_code), 0);
            end
            if (exp == C_TOG) check("R9 window low", int'(tx_en), 0);
            else              check("R10 en kept", int'(tx_en), int'(tx_en_cfg));
        end
        @(negedge clk);
        check("R9 en restored", int'(tx_en), int'(tx_en_cfg));
    endtask

    int f_v = 0, p_v = 0, d_v = 0;

    task automatic t_reset();
        check("R1 valid", int'(act_valid), 0);
        check("R1 code", int'(act_code), 0);
        check("R1 tx_en", int'(tx_en), 1);
    endtask

    task automatic t_first();
        // R1: saved samples start at zero, so an unchanged zero tick is quiet (R6)
        pulse(0, 0, 0, 0, C_NONE, "R6 zero tick");
        // R5: drop moved with saved values all zero -> stall
        d_v = 1;
        pulse(0, 0, 0, d_v, C_TOG, "R5 first stall");
    endtask

    task automatic t_escalate();
        // R7: four more toggles then a reset, then toggling resumes
        for (int k = 0; k < 4; k++) begin
            d_v++;
            pulse(f_v, p_v, 0, d_v, C_TOG, "R7 toggle");
        end
        d_v++;
        pulse(f_v, p_v, 0, d_v, C_RST, "R7 reset");
        d_v++;
        pulse(f_v, p_v, 0, d_v, C_TOG, "R7 after reset");
    endtask

    task automatic t_progress();
        f_v = 9;
        pulse(f_v, p_v, 0, d_v + 5, C_NONE, "R3 frames moved");
        d_v += 6;
        pulse(f_v, p_v, 0, d_v, C_TOG, "R8 frames saved");
        p_v = 3;
        pulse(f_v, p_v, 0, d_v + 1, C_NONE, "R3 pause moved");
        d_v += 2;
        pulse(f_v, p_v, 0, d_v, C_TOG, "R8 pause saved");
        // escalation was cleared by R3: full run needed before reset
        for (int k = 0; k < 4; k++) begin
            d_v++;
            pulse(f_v, p_v, 0, d_v, C_TOG, "R3 count cleared");
        end
        d_v++;
        pulse(f_v, p_v, 0, d_v, C_RST, "R3 reset after full run");
    endtask

    task automatic t_busy();
        d_v++;
        pulse(f_v, p_v, 0, d_v, C_TOG, "R5 stall");
        d_v++;
        pulse(f_v, p_v, 7, d_v, C_NONE, "R4 sop pending");
        d_v++;
        pulse(f_v, p_v, 0, d_v, C_NONE, "R6 prev sop nonzero");
        d_v++;
        pulse(f_v, p_v, 0, d_v, C_TOG, "R8 sop saved");
    endtask

    task automatic t_quiet();
        // same drop -> quiet, clears the count (R6)
        pulse(f_v, p_v, 0, d_v, C_NONE, "R6 drop still");
        for (int k = 0; k < 5; k++) begin
            d_v++;
            pulse(f_v, p_v, 0, d_v, C_TOG, "R6 count cleared");
        end
        d_v++;
        pulse(f_v, p_v, 0, d_v, C_RST, "R6 reset after full run");
    endtask

    task automatic t_cfg_low();
        @(negedge clk);
        tx_en_cfg = 1'b0;
        @(negedge clk);
        check("R9 cfg low", int'(tx_en), 0);
        d_v++;
        pulse(f_v, p_v, 0, d_v, C_TOG, "R9 toggle with cfg low");
        tx_en_cfg = 1'b1;
        @(negedge clk);
        check("R9 cfg back", int'(tx_en), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first();
        t_escalate();
        t_progress();
        t_busy();
        t_quiet();
        t_cfg_low();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule